// File: doc/BRIEF.md
# Display Control Bus Master

This block lets a host reach a set of small peripheral devices over a narrow, byte-wide control bus. The host first loads a 32-bit mode word. The mode word picks the target device, the register inside that device, how many bytes move, the byte order, whether the register select steps forward after each byte, and the chip-select timing. It also picks whether the slave ends the strobe with an acknowledge.

A single-cycle data write starts an outbound transfer. A single-cycle read request starts an inbound transfer. Each byte runs through three phases: a setup phase with address, select and data driven and the strobe low, a strobe phase, and a hold phase. The host polls `busy` and collects read data from `data_rdata` once `busy` has fallen. In asynchronous acknowledge mode a timeout ends a strobe that gets no answer and raises `ack_err`.

Top module: `ctlbus_master`

## Requirements
- R1: A transfer starts when `data_wr` or `data_rd` is high for one cycle while `busy` is low. `busy` rises in the next cycle and falls after the hold phase of the last byte. While `busy` is high, `data_wr`, `data_rd` and `mode_wr` are ignored. `bus_addr` is mode bits [10:7] and does not change during a transfer.
- R2: The byte count is 4 when mode bit 2 (pack) is set. Otherwise it comes from mode bits [1:0]: code 0 gives 4 bytes, and codes 1 to 3 give 1 to 3 bytes.
- R3: With mode bit 28 clear, bytes go out from the most significant end: [31:24] first, then [23:16], and so on. With bit 28 set, the order starts at [7:0] and moves upward.
- R4: With no acknowledge mode, each byte takes setup+1 cycles with `bus_cs` low, then width+1 cycles with `bus_cs` high, then hold+1 cycles with `bus_cs` low. Width is mode bits [17:13], hold is bits [22:18] and setup is bits [27:23]. Address, select, direction and data stay steady through each strobe.
- R5: `bus_sel` is loaded from mode bits [6:4] when the mode is written. When mode bit 3 is set, it advances by one (modulo 8) after each byte. The advanced value carries into the next transfer until the mode is written again.
- R6: When mode bit 11 is set, the strobe ends at the first clock edge where `bus_ack` is high, and the width field is ignored.
- R7: When mode bit 12 is set and bit 11 is clear, `bus_ack` passes through a two-flop synchronizer. The strobe ends at the edge where the synchronized acknowledge is high. An acknowledge first seen high at the falling edge of strobe cycle D gives a strobe of D+2 cycles.
- R8: In asynchronous mode, a strobe with no acknowledge ends after TIMEOUT_CYC cycles and sets `ack_err`. `ack_err` stays set until the next accepted start clears it.
- R9: On reads, `bus_doe` stays low, `bus_rnw` is high, and `bus_din` is captured at the end of each strobe. Bytes fill `data_rdata` from [31:24] downward, or from [7:0] upward when bit 28 is set. Lanes not filled read as zero.
- R10: A start request while the mode addresses device 15 (reserved) is dropped. `busy` stays low and no strobe occurs.
- R11: After reset, `busy`, `bus_cs`, `bus_doe` and `ack_err` are low, and `data_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Load mode word |
| mode_wdata | input | 32 | Mode word |
| data_wr | input | 1 | Start an outbound transfer |
| data_wdata | input | 32 | Outbound data word |
| data_rd | input | 1 | Start an inbound transfer |
| data_rdata | output | 32 | Assembled inbound data |
| busy | output | 1 | Transfer in progress |
| ack_err | output | 1 | Acknowledge timeout seen |
| bus_addr | output | 4 | Slave device address |
| bus_sel | output | 3 | Register select inside the slave |
| bus_cs | output | 1 | Chip-select strobe |
| bus_rnw | output | 1 | High for read, low for write |
| bus_dout | output | 8 | Outbound byte |
| bus_doe | output | 1 | Outbound byte valid |
| bus_din | input | 8 | Inbound byte from the slave |
| bus_ack | input | 1 | Slave acknowledge |

## Verification
`busy` is due high at the falling edge right after the start edge. Without acknowledge it stays high for exactly bytes*(setup+width+hold+3) cycles. The bench counts the falling edges at which `busy` is high and compares the count with that sum.

Strobe lengths are counted the same way at falling edges. The expected length is width+1 with no acknowledge, D with synchronous acknowledge (the acknowledge is raised at the D-th falling edge of the strobe), D+2 with asynchronous acknowledge, and TIMEOUT_CYC on timeout.

Read data and `ack_err` are sampled only after `busy` has fallen, because the last capture and the error update occur on or before that edge.

// File: rtl/ctlbus_pkg.sv
package ctlbus_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  // Mode word bits [28:0], most significant field first
  typedef struct packed {
    logic       swap;    // 28
    logic [4:0] setup;   // 27:23
    logic [4:0] hold;    // 22:18
    logic [4:0] width;   // 17:13
    logic       aack;    // 12
    logic       sack;    // 11
    logic [3:0] addr;    // 10:7
    logic [2:0] sel;     // 6:4
    logic       inc;     // 3
    logic       pack;    // 2
    logic [1:0] wcode;   // 1:0
  } mode_t;

  localparam logic [3:0] ADDR_RESERVED = 4'hF;

  function automatic logic [2:0] bytes_of(input mode_t m);
    if (m.pack || (m.wcode == 2'd0)) return 3'd4;
    return {1'b0, m.wcode};
  endfunction

  function automatic logic [1:0] lane_of(input logic [1:0] idx, input logic swap);
    return swap ? idx : (2'd3 - idx);
  endfunction

endpackage

// File: rtl/ctlbus_ack_sync.sv
module ctlbus_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[g] <= 1'b0;
      else        pipe[g] <= (g == 0) ? d : pipe[(g == 0) ? 0 : g-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/ctlbus_seq.sv
module ctlbus_seq
  import ctlbus_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  mode_t      mode,
  input  logic       ack_now,
  input  logic       ack_sync,
  output phase_e     phase,
  output logic [1:0] idx,
  output logic       strobe_end,
  output logic       byte_end,
  output logic       timeout
);
  localparam int TW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [TW-1:0] TMO_LAST = TW'(TIMEOUT_CYC - 1);

  phase_e        phase_d;
  logic [4:0]    cnt_q, cnt_d;
  logic [1:0]    idx_d;
  logic [TW-1:0] tmo_q, tmo_d;
  logic          last_byte;

  assign last_byte = (idx == 2'(bytes_of(mode) - 3'd1));

  always_comb begin
    phase_d    = phase;
    cnt_d      = cnt_q;
    idx_d      = idx;
    tmo_d      = tmo_q;
    strobe_end = 1'b0;
    byte_end   = 1'b0;
    timeout    = 1'b0;
    case (phase)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_SETUP;
          cnt_d   = 5'd0;
          idx_d   = 2'd0;
        end
      end
      PH_SETUP: begin
        if (cnt_q == mode.setup) begin
          phase_d = PH_STROBE;
          cnt_d   = 5'd0;
          tmo_d   = '0;
        end else begin
          cnt_d = cnt_q + 5'd1;
        end
      end
      PH_STROBE: begin
        cnt_d = cnt_q + 5'd1;
        tmo_d = tmo_q + 1'b1;
        if (mode.sack) begin
          strobe_end = ack_now;
        end else if (mode.aack) begin
          if (ack_sync) begin
            strobe_end = 1'b1;
          end else if (tmo_q == TMO_LAST) begin
            strobe_end = 1'b1;
            timeout    = 1'b1;
          end
        end else begin
          strobe_end = (cnt_q == mode.width);
        end
        if (strobe_end) begin
          phase_d = PH_HOLD;
          cnt_d   = 5'd0;
        end
      end
      default: begin
        if (cnt_q == mode.hold) begin
          byte_end = 1'b1;
          cnt_d    = 5'd0;
          if (last_byte) begin
            phase_d = PH_IDLE;
          end else begin
            phase_d = PH_SETUP;
            idx_d   = idx + 2'd1;
          end
        end else begin
          cnt_d = cnt_q + 5'd1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt_q <= 5'd0;
      idx   <= 2'd0;
      tmo_q <= '0;
    end else begin
      phase <= phase_d;
      cnt_q <= cnt_d;
      idx   <= idx_d;
      tmo_q <= tmo_d;
    end
  end
endmodule

// File: rtl/ctlbus_lanes.sv
module ctlbus_lanes
  import ctlbus_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_wr,
  input  logic        clear_rd,
  input  logic [31:0] wdata,
  input  logic [1:0]  idx,
  input  logic        swap,
  input  logic        capture,
  input  logic [7:0]  din,
  output logic [7:0]  tx_byte,
  output logic [31:0] rdata
);
  logic [31:0]      wdata_q;
  logic [3:0][7:0]  rd_q;
  logic [1:0]       lane;

  assign lane    = lane_of(idx, swap);
  assign tx_byte = wdata_q[{lane, 3'b000} +: 8];
  assign rdata   = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wdata_q <= 32'd0;
    else if (load_wr) wdata_q <= wdata;
  end

  for (genvar g = 0; g < 4; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              rd_q[g] <= 8'd0;
      else if (clear_rd)                       rd_q[g] <= 8'd0;
      else if (capture && (lane == 2'(g)))     rd_q[g] <= din;
    end
  end
endmodule

// File: rtl/ctlbus_master.sv
module ctlbus_master
  import ctlbus_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_wr,
  input  logic [31:0] mode_wdata,
  input  logic        data_wr,
  input  logic [31:0] data_wdata,
  input  logic        data_rd,
  output logic [31:0] data_rdata,
  output logic        busy,
  output logic        ack_err,
  output logic [3:0]  bus_addr,
  output logic [2:0]  bus_sel,
  output logic        bus_cs,
  output logic        bus_rnw,
  output logic [7:0]  bus_dout,
  output logic        bus_doe,
  input  logic [7:0]  bus_din,
  input  logic        bus_ack
);
  logic [1:0] rst_pipe;
  logic       rst_l;
  mode_t      mode_q;
  logic [2:0] sel_q;
  logic       rnw_q, err_q;
  logic       go, go_wr, go_rd;
  phase_e     phase;
  logic [1:0] idx;
  logic       strobe_end, byte_end, timeout, ack_s;
  logic [7:0] tx_byte;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_l = rst_pipe[1];

  assign busy  = (phase != PH_IDLE);
  assign go    = (data_wr || data_rd) && !busy && (mode_q.addr != ADDR_RESERVED);
  assign go_wr = go && data_wr;
  assign go_rd = go && !data_wr;

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      mode_q <= '0;
      sel_q  <= 3'd0;
      rnw_q  <= 1'b1;
      err_q  <= 1'b0;
    end else begin
      if (mode_wr && !busy) begin
        mode_q <= mode_t'(mode_wdata[28:0]);
        sel_q  <= mode_wdata[6:4];
      end else if (byte_end && mode_q.inc) begin
        sel_q  <= sel_q + 3'd1;
      end
      if (go)           rnw_q <= !data_wr;
      if (go)           err_q <= 1'b0;
      else if (timeout) err_q <= 1'b1;
    end
  end

  ctlbus_ack_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk   (clk),
    .rst_n (rst_l),
    .d     (bus_ack),
    .q     (ack_s)
  );

  ctlbus_seq #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_l),
    .start      (go),
    .mode       (mode_q),
    .ack_now    (bus_ack),
    .ack_sync   (ack_s),
    .phase      (phase),
    .idx        (idx),
    .strobe_end (strobe_end),
    .byte_end   (byte_end),
    .timeout    (timeout)
  );

  ctlbus_lanes u_lanes (
    .clk      (clk),
    .rst_n    (rst_l),
    .load_wr  (go_wr),
    .clear_rd (go_rd),
    .wdata    (data_wdata),
    .idx      (idx),
    .swap     (mode_q.swap),
    .capture  (strobe_end && rnw_q),
    .din      (bus_din),
    .tx_byte  (tx_byte),
    .rdata    (data_rdata)
  );

  assign ack_err  = err_q;
  assign bus_addr = mode_q.addr;
  assign bus_sel  = sel_q;
  assign bus_cs   = (phase == PH_STROBE);
  assign bus_rnw  = rnw_q;
  assign bus_doe  = busy && !rnw_q;
  assign bus_dout = bus_doe ? tx_byte : 8'd0;
endmodule

// File: rtl/ctlbus_master_chk.sv
module ctlbus_master_chk (
  input logic       clk,
  input logic       rst_l,
  input logic       data_wr,
  input logic       data_rd,
  input logic       busy,
  input logic       ack_err,
  input logic [3:0] bus_addr,
  input logic [2:0] bus_sel,
  input logic       bus_cs,
  input logic       bus_rnw,
  input logic       bus_doe,
  input logic       mode_sack,
  input logic       mode_aack
);
  // R4: the strobe only appears inside a transfer
  p_cs_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_l)
    bus_cs |-> busy);

  // R1: device address frozen while busy
  p_addr_frozen_r1: assert property (@(posedge clk) disable iff (!rst_l)
    (busy && $past(busy)) |-> $stable(bus_addr));

  // R5: register select steady across a strobe
  p_sel_steady_r5: assert property (@(posedge clk) disable iff (!rst_l)
    (bus_cs && $past(bus_cs)) |-> $stable(bus_sel));

  // R9: data never driven toward the slave on reads
  p_doe_dir_r9: assert property (@(posedge clk) disable iff (!rst_l)
    bus_doe |-> !bus_rnw);

  // R8: error only rises in asynchronous acknowledge mode
  p_err_async_r8: assert property (@(posedge clk) disable iff (!rst_l)
    $rose(ack_err) |-> (mode_aack && !mode_sack));

  // R10: start toward the reserved device is dropped
  p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_l)
    ((data_wr || data_rd) && !busy && (bus_addr == 4'hF)) |=> !busy);
endmodule

bind ctlbus_master ctlbus_master_chk u_chk (
  .clk       (clk),
  .rst_l     (rst_l),
  .data_wr   (data_wr),
  .data_rd   (data_rd),
  .busy      (busy),
  .ack_err   (ack_err),
  .bus_addr  (bus_addr),
  .bus_sel   (bus_sel),
  .bus_cs    (bus_cs),
  .bus_rnw   (bus_rnw),
  .bus_doe   (bus_doe),
  .mode_sack (mode_q.sack),
  .mode_aack (mode_q.aack)
);

// File: tb/ctlbus_master_tb.sv
`timescale 1ns/1ps
module ctlbus_master_tb;
  localparam int TMO = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr = 1'b0;
  logic [31:0] mode_wdata = 32'd0;
  logic        data_wr = 1'b0;
  logic [31:0] data_wdata = 32'd0;
  logic        data_rd = 1'b0;
  logic [31:0] data_rdata;
  logic        busy, ack_err;
  logic [3:0]  bus_addr;
  logic [2:0]  bus_sel;
  logic        bus_cs, bus_rnw, bus_doe;
  logic [7:0]  bus_dout, bus_din;
  logic        bus_ack = 1'b0;

  int checks = 0;
  int errors = 0;

  // slave model and acknowledge driver
  bit ack_on  = 1'b0;
  int ack_dly = 1;
  int hi_cnt  = 0;

  // per-transfer log
  logic [7:0] lg_d[8];
  logic [3:0] lg_a[8];
  logic [2:0] lg_s[8];
  logic       lg_rnw[8];
  logic       lg_oe[8];
  int         lg_len[8];
  int         n_str, busy_cyc;
  bit         stab_bad;

  always #4 clk = ~clk;

  ctlbus_master #(.TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .data_wr(data_wr), .data_wdata(data_wdata),
    .data_rd(data_rd), .data_rdata(data_rdata),
    .busy(busy), .ack_err(ack_err),
    .bus_addr(bus_addr), .bus_sel(bus_sel), .bus_cs(bus_cs),
    .bus_rnw(bus_rnw), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_din(bus_din), .bus_ack(bus_ack)
  );

  assign bus_din = {1'b1, bus_sel, bus_addr};

  always @(negedge clk) begin
    if (bus_cs && ack_on) begin
      hi_cnt  <= hi_cnt + 1;
      bus_ack <= ((hi_cnt + 1) >= ack_dly);
    end else begin
      hi_cnt  <= 0;
      bus_ack <= 1'b0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired: got %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [1:0] wc, input logic pack, input logic inc,
                                     input logic [2:0] sel, input logic [3:0] addr,
                                     input logic sack, input logic aack,
                                     input logic [4:0] w, input logic [4:0] h,
                                     input logic [4:0] s, input logic swap);
    return {3'b000, swap, s, h, w, aack, sack, addr, sel, inc, pack, wc};
  endfunction

  task automatic xfer(input logic [31:0] mode, input bit wmode, input logic [31:0] wd,
                      input bit rd, input bit poke);
    bit prev_cs;
    if (wmode) begin
      @(negedge clk); mode_wr = 1'b1; mode_wdata = mode;
    end
    @(negedge clk);
    mode_wr = 1'b0;
    if (rd) data_rd = 1'b1;
    else begin data_wr = 1'b1; data_wdata = wd; end
    n_str = 0; busy_cyc = 0; stab_bad = 1'b0; prev_cs = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      data_wr = 1'b0; data_rd = 1'b0; mode_wr = 1'b0;
      if (poke && i == 2) begin
        data_wr = 1'b1; data_wdata = ~wd;
        mode_wr = 1'b1; mode_wdata = mode ^ (32'h3 << 7);
      end
      if (!busy) break;
      busy_cyc++;
      if (bus_cs && !prev_cs) begin
        if (n_str < 8) begin
          lg_d[n_str] = bus_dout; lg_a[n_str] = bus_addr; lg_s[n_str] = bus_sel;
          lg_rnw[n_str] = bus_rnw; lg_oe[n_str] = bus_doe; lg_len[n_str] = 1;
        end
        n_str++;
      end else if (bus_cs && n_str > 0 && n_str <= 8) begin
        lg_len[n_str-1]++;
        if (bus_dout !== lg_d[n_str-1] || bus_addr !== lg_a[n_str-1] ||
            bus_sel !== lg_s[n_str-1] || bus_rnw !== lg_rnw[n_str-1])
          stab_bad = 1'b1;
      end
      prev_cs = bus_cs;
    end
    data_wr = 1'b0; data_rd = 1'b0; mode_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11", "busy after reset", {31'd0, busy}, 32'd0);
    chk("R11", "cs after reset", {31'd0, bus_cs}, 32'd0);
    chk("R11", "doe after reset", {31'd0, bus_doe}, 32'd0);
    chk("R11", "err after reset", {31'd0, ack_err}, 32'd0);
    chk("R11", "rdata after reset", data_rdata, 32'd0);
  endtask

  task automatic t_packed_write;
    logic [7:0] e[4] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
    xfer(mk(2'd1, 1'b1, 1'b0, 3'd2, 4'd5, 1'b0, 1'b0, 5'd2, 5'd0, 5'd1, 1'b0),
         1'b1, 32'hA1B2C3D4, 1'b0, 1'b0);
    chk("R2", "packed byte count", n_str, 4);
    chk("R4", "busy cycles packed", busy_cyc, 24);
    chk("R4", "strobe stability", {31'd0, stab_bad}, 32'd0);
    for (int k = 0; k < 4; k++) begin
      chk("R3", "msb-first byte", {24'd0, lg_d[k]}, {24'd0, e[k]});
      chk("R4", "strobe len w=2", lg_len[k], 3);
      chk("R1", "address", {28'd0, lg_a[k]}, 32'd5);
      chk("R5", "select fixed", {29'd0, lg_s[k]}, 32'd2);
      chk("R9", "write direction", {30'd0, lg_rnw[k], lg_oe[k]}, 32'd1);
    end
  endtask

  task automatic t_swap_write;
    logic [7:0] e[3] = '{8'h44, 8'h33, 8'h22};
    xfer(mk(2'd3, 1'b0, 1'b0, 3'd0, 4'd1, 1'b0, 1'b0, 5'd0, 5'd1, 5'd0, 1'b1),
         1'b1, 32'h11223344, 1'b0, 1'b0);
    chk("R2", "3-byte count", n_str, 3);
    chk("R4", "busy cycles h=1", busy_cyc, 12);
    for (int k = 0; k < 3; k++) begin
      chk("R3", "swapped byte", {24'd0, lg_d[k]}, {24'd0, e[k]});
      chk("R4", "strobe len w=0", lg_len[k], 1);
    end
  endtask

  task automatic t_code0_write;
    xfer(mk(2'd0, 1'b0, 1'b0, 3'd0, 4'd2, 1'b0, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0),
         1'b1, 32'h01020304, 1'b0, 1'b0);
    chk("R2", "code 0 count", n_str, 4);
    chk("R4", "busy cycles minimal", busy_cyc, 12);
    chk("R3", "last byte code 0", {24'd0, lg_d[3]}, 32'h04);
  endtask

  task automatic t_autoinc;
    xfer(mk(2'd2, 1'b0, 1'b1, 3'd6, 4'd4, 1'b0, 1'b0, 5'd1, 5'd0, 5'd0, 1'b0),
         1'b1, 32'hCAFE0000, 1'b0, 1'b0);
    chk("R5", "inc sel first", {29'd0, lg_s[0]}, 32'd6);
    chk("R5", "inc sel second", {29'd0, lg_s[1]}, 32'd7);
    chk("R3", "inc byte second", {24'd0, lg_d[1]}, 32'hFE);
    xfer(32'd0, 1'b0, 32'h12345678, 1'b0, 1'b0);
    chk("R5", "sel wraps and carries", {29'd0, lg_s[0]}, 32'd0);
    chk("R5", "sel carries second", {29'd0, lg_s[1]}, 32'd1);
    chk("R3", "carry transfer bytes", {16'd0, lg_d[0], lg_d[1]}, 32'h1234);
  endtask

  task automatic t_reads;
    xfer(mk(2'd3, 1'b0, 1'b1, 3'd1, 4'd9, 1'b0, 1'b0, 5'd1, 5'd1, 5'd1, 1'b0),
         1'b1, 32'd0, 1'b1, 1'b0);
    chk("R9", "read msb fill", data_rdata, 32'h99A9B900);
    chk("R9", "read direction", {30'd0, lg_rnw[0], lg_oe[0]}, 32'd2);
    xfer(mk(2'd2, 1'b0, 1'b1, 3'd4, 4'd3, 1'b0, 1'b0, 5'd0, 5'd0, 5'd0, 1'b1),
         1'b1, 32'd0, 1'b1, 1'b0);
    chk("R9", "read swapped fill", data_rdata, 32'h0000D3C3);
  endtask

  task automatic t_sync_ack;
    ack_on = 1'b1; ack_dly = 3;
    xfer(mk(2'd1, 1'b0, 1'b0, 3'd0, 4'd6, 1'b1, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0),
         1'b1, 32'h5A000000, 1'b0, 1'b0);
    chk("R6", "sync strobe stretched", lg_len[0], 3);
    ack_dly = 2;
    xfer(mk(2'd1, 1'b0, 1'b0, 3'd0, 4'd6, 1'b1, 1'b0, 5'd31, 5'd0, 5'd0, 1'b0),
         1'b1, 32'h5A000000, 1'b0, 1'b0);
    chk("R6", "sync strobe cut short", lg_len[0], 2);
    ack_on = 1'b0;
  endtask

  task automatic t_async_ack;
    ack_on = 1'b1; ack_dly = 2;
    xfer(mk(2'd1, 1'b0, 1'b0, 3'd0, 4'd7, 1'b0, 1'b1, 5'd0, 5'd0, 5'd0, 1'b0),
         1'b1, 32'h77000000, 1'b0, 1'b0);
    chk("R7", "async strobe len", lg_len[0], 4);
    chk("R7", "no error with ack", {31'd0, ack_err}, 32'd0);
    ack_on = 1'b0;
    xfer(mk(2'd1, 1'b0, 1'b0, 3'd0, 4'd7, 1'b0, 1'b1, 5'd0, 5'd0, 5'd0, 1'b0),
         1'b1, 32'h77000000, 1'b0, 1'b0);
    chk("R8", "timeout strobe len", lg_len[0], TMO);
    chk("R8", "error set", {31'd0, ack_err}, 32'd1);
    ack_on = 1'b1; ack_dly = 1;
    xfer(32'd0, 1'b0, 32'h78000000, 1'b0, 1'b0);
    chk("R8", "error cleared by start", {31'd0, ack_err}, 32'd0);
    chk("R7", "async strobe len d=1", lg_len[0], 3);
    ack_on = 1'b0;
  endtask

  task automatic t_reserved;
    xfer(mk(2'd1, 1'b0, 1'b0, 3'd0, 4'd15, 1'b0, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0),
         1'b1, 32'hFF000000, 1'b0, 1'b0);
    chk("R10", "reserved busy", busy_cyc, 0);
    chk("R10", "reserved strobes", n_str, 0);
  endtask

  task automatic t_busy_ignore;
    xfer(mk(2'd0, 1'b1, 1'b0, 3'd2, 4'd5, 1'b0, 1'b0, 5'd2, 5'd0, 5'd1, 1'b0),
         1'b1, 32'hA1B2C3D4, 1'b0, 1'b1);
    chk("R1", "count unchanged by poke", n_str, 4);
    chk("R1", "busy cycles unchanged", busy_cyc, 24);
    chk("R1", "address held", {28'd0, lg_a[3]}, 32'd5);
    chk("R1", "data held", {24'd0, lg_d[3]}, 32'hD4);
    xfer(32'd0, 1'b0, 32'h55667788, 1'b0, 1'b0);
    chk("R1", "mode write while busy dropped", {28'd0, lg_a[0]}, 32'd5);
    chk("R1", "next transfer bytes", {lg_d[0], lg_d[1], lg_d[2], lg_d[3]}, 32'h55667788);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_packed_write();
    t_swap_write();
    t_code0_write();
    t_autoinc();
    t_reads();
    t_sync_ack();
    t_async_ack();
    t_reserved();
    t_busy_ignore();
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule